// File: doc/BRIEF.md
# Submission Queue Fetch Tracker

This block keeps the controller's view of several circular command queues that live in host memory. For each queue it holds a base address, a size, an enable, a consumer index (head) and a producer index (tail). The host moves the tail only by writing a new index to that queue's tail doorbell. The head moves only when the controller fetches an entry. A queue reports work pending whenever it is enabled and its head and tail differ.

When the controller requests a fetch from a queue that has work pending, the block issues one read of a 64-byte slot. The read address is the queue base plus the head times 64. The head then advances, wrapping to zero after the last slot. When the first command word returns from host memory, the block splits it into its opcode, fused-operation code, data-pointer type and command identifier. It presents these together with the queue number and the updated head index, so that a later completion entry can report how far the queue has been consumed. Queue 0 is the administrative queue, and the higher numbers are I/O queues. Only one fetch is in flight at a time.

Top module: `sq_fetch_tracker`

## Requirements
- R1: After reset, no queue is enabled or pending, `mem_req_o`, `cmd_valid_o` and `db_err_o` are low, and `fetch_ready_o` is high.
- R2: A doorbell write to an enabled queue with an index below that queue's size sets its tail. From the next cycle, `pending_o[q]` equals (head != tail).
- R3: A doorbell write is ignored, with `db_err_o` high for exactly the next cycle, in any of these cases: the index is not below the queue size, the queue is disabled, or the queue number is not below the number of queues. The tail stays unchanged.
- R4: A fetch request to a pending queue while `fetch_ready_o` is high makes `mem_req_o` high for exactly the next cycle, with `mem_addr_o` = base + head*64.
- R5: Each issued fetch advances that queue's head by one. The head wraps from size-1 to 0.
- R6: A fetch request to a queue with no pending entry, or to an out-of-range queue number, is ignored. No memory read is issued and no command is produced.
- R7: The cycle after `mem_rvalid_i` is seen while a fetch is outstanding, `cmd_valid_o` is high for one cycle. Command word bits 7:0 appear as `cmd_opc_o`, bits 9:8 as `cmd_fuse_o`, bits 15:14 as `cmd_psdt_o` and bits 31:16 as `cmd_cid_o`. Bits 13:10 have no effect.
- R8: With each command, `cmd_qid_o` gives the source queue, `cmd_admin_o` is high only for queue 0, and `cmd_sq_head_o` gives that queue's head after the fetched slot was consumed.
- R9: A configuration write sets a queue's base, size and enable, and clears its head and tail to 0. A disabled queue never shows pending.
- R10: At most one fetch is outstanding. `fetch_ready_o` is low from the cycle `mem_req_o` rises until the response is taken, and `mem_req_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Queue configuration write strobe |
| cfg_qid_i | input | QID_W | Queue being configured |
| cfg_en_i | input | 1 | Enable value for the queue |
| cfg_base_i | input | ADDR_W | Queue base byte address |
| cfg_size_i | input | IDX_W+1 | Number of slots (at least 2) |
| db_we_i | input | 1 | Tail doorbell write strobe |
| db_qid_i | input | QID_W | Doorbell target queue |
| db_tail_i | input | IDX_W | New tail index |
| db_err_o | output | 1 | Pulse: last doorbell write was rejected |
| pending_o | output | NUM_Q | Per-queue work-pending flags |
| fetch_req_i | input | 1 | Request one fetch |
| fetch_qid_i | input | QID_W | Queue to fetch from |
| fetch_ready_o | output | 1 | No fetch outstanding |
| mem_req_o | output | 1 | Host memory read pulse |
| mem_addr_o | output | ADDR_W | Slot byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | First command word of the slot |
| cmd_valid_o | output | 1 | Decoded command pulse |
| cmd_qid_o | output | QID_W | Source queue |
| cmd_admin_o | output | 1 | Source is the administrative queue |
| cmd_opc_o | output | 8 | Opcode |
| cmd_fuse_o | output | 2 | Fused-operation code |
| cmd_psdt_o | output | 2 | Data-pointer type |
| cmd_cid_o | output | 16 | Command identifier |
| cmd_sq_head_o | output | IDX_W | Head after this fetch |

## Verification
A head that is off by one, or that fails to wrap, shows in the very next fetch. The read address would miss base + head*64, and the reported head would disagree with the arithmetic model. The queue would also keep or lose its pending flag one fetch too early or too late. A tail that takes a rejected doorbell value shows one cycle later in `pending_o`. A stuck busy state shows at once as `fetch_ready_o` staying low and later requests producing no read. A field decoded from the wrong bits shows on the same `cmd_valid_o` pulse, because each slot's returned word is a distinct function of its address.

// File: rtl/sqf_pkg.sv
package sqf_pkg;
  localparam int SLOT_SHIFT = 6;  // 64-byte slots

  typedef struct packed {
    logic [15:0] cid;
    logic [1:0]  psdt;
    logic [1:0]  fuse;
    logic [7:0]  opc;
  } dw0_fields_t;

  function automatic dw0_fields_t split_dw0(logic [31:0] w);
    dw0_fields_t f;
    f.opc  = w[7:0];
    f.fuse = w[9:8];
    f.psdt = w[15:14];
    f.cid  = w[31:16];
    return f;
  endfunction
endpackage

// File: rtl/sq_queue_state.sv
module sq_queue_state #(
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_en_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [IDX_W:0]    cfg_size_i,
  input  logic              db_we_i,
  input  logic [IDX_W-1:0]  db_tail_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [IDX_W-1:0]  head_o,
  output logic              pending_o,
  output logic              db_bad_o
);
  logic              en_q;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W:0]    size_q;
  logic [IDX_W-1:0]  head_q, tail_q;
  logic              last_slot;

  assign db_bad_o  = db_we_i & (~en_q | ({1'b0, db_tail_i} >= size_q));
  assign last_slot = ({1'b0, head_q} == size_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      base_q <= '0;
      size_q <= '0;
      head_q <= '0;
      tail_q <= '0;
    end else if (cfg_we_i) begin
      en_q   <= cfg_en_i;
      base_q <= cfg_base_i;
      size_q <= cfg_size_i;
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (db_we_i && !db_bad_o) tail_q <= db_tail_i;
      if (adv_i) head_q <= last_slot ? '0 : head_q + 1'b1;
    end
  end

  assign base_o    = base_q;
  assign head_o    = head_q;
  assign pending_o = en_q & (head_q != tail_q);

  a_r5_head_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> ({1'b0, head_q} < size_q));
  a_r9_head_moves_only_on_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !cfg_we_i) |=> $stable(head_q));
  a_r3_rejected_tail_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_bad_o && !cfg_we_i) |=> $stable(tail_q));
  a_r6_no_advance_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> pending_o);
endmodule

// File: rtl/sq_fetch_ctrl.sv
module sq_fetch_ctrl
  import sqf_pkg::*;
#(
  parameter int NUM_Q  = 3,
  parameter int QID_W  = 2,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         fetch_req_i,
  input  logic [QID_W-1:0]             fetch_qid_i,
  input  logic [NUM_Q-1:0]             pending_i,
  input  logic [NUM_Q-1:0][ADDR_W-1:0] base_i,
  input  logic [NUM_Q-1:0][IDX_W-1:0]  head_i,
  input  logic                         mem_rvalid_i,
  output logic                         ready_o,
  output logic [NUM_Q-1:0]             adv_o,
  output logic                         mem_req_o,
  output logic [ADDR_W-1:0]            mem_addr_o,
  output logic [QID_W-1:0]             cur_qid_o,
  output logic                         rsp_o
);
  logic              busy_q, req_q;
  logic [ADDR_W-1:0] addr_q, addr_sel;
  logic [QID_W-1:0]  qid_q;
  logic              go;

  always_comb begin
    addr_sel = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      adv_o[q] = ~busy_q & fetch_req_i & (fetch_qid_i == QID_W'(q)) & pending_i[q];
      if (adv_o[q])
        addr_sel = base_i[q] + (ADDR_W'(head_i[q]) << SLOT_SHIFT);
    end
  end
  assign go = |adv_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      addr_q <= '0;
      qid_q  <= '0;
    end else begin
      req_q <= go;
      if (go) begin
        busy_q <= 1'b1;
        addr_q <= addr_sel;
        qid_q  <= fetch_qid_i;
      end else if (busy_q && mem_rvalid_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign ready_o    = ~busy_q;
  assign mem_req_o  = req_q;
  assign mem_addr_o = addr_q;
  assign cur_qid_o  = qid_q;
  assign rsp_o      = busy_q & mem_rvalid_i;

  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  a_r10_busy_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o);
  a_r4_one_queue_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(adv_o));
endmodule

// File: rtl/sq_fetch_tracker.sv
module sq_fetch_tracker
  import sqf_pkg::*;
#(
  parameter int NUM_Q  = 3,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 32,
  localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [QID_W-1:0]  cfg_qid_i,
  input  logic              cfg_en_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [IDX_W:0]    cfg_size_i,
  input  logic              db_we_i,
  input  logic [QID_W-1:0]  db_qid_i,
  input  logic [IDX_W-1:0]  db_tail_i,
  output logic              db_err_o,
  output logic [NUM_Q-1:0]  pending_o,
  input  logic              fetch_req_i,
  input  logic [QID_W-1:0]  fetch_qid_i,
  output logic              fetch_ready_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              cmd_valid_o,
  output logic [QID_W-1:0]  cmd_qid_o,
  output logic              cmd_admin_o,
  output logic [7:0]        cmd_opc_o,
  output logic [1:0]        cmd_fuse_o,
  output logic [1:0]        cmd_psdt_o,
  output logic [15:0]       cmd_cid_o,
  output logic [IDX_W-1:0]  cmd_sq_head_o
);
  logic [NUM_Q-1:0]             cfg_sel, db_sel, db_bad, adv;
  logic [NUM_Q-1:0][ADDR_W-1:0] base_v;
  logic [NUM_Q-1:0][IDX_W-1:0]  head_v;
  logic [QID_W-1:0]             cur_qid;
  logic                         rsp;
  logic                         db_err_d, db_err_q;
  logic [IDX_W-1:0]             cur_head;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    assign cfg_sel[q] = cfg_we_i & (cfg_qid_i == QID_W'(q));
    assign db_sel[q]  = db_we_i & (db_qid_i == QID_W'(q));
    sq_queue_state #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_state (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_we_i  (cfg_sel[q]),
      .cfg_en_i  (cfg_en_i),
      .cfg_base_i(cfg_base_i),
      .cfg_size_i(cfg_size_i),
      .db_we_i   (db_sel[q]),
      .db_tail_i (db_tail_i),
      .adv_i     (adv[q]),
      .base_o    (base_v[q]),
      .head_o    (head_v[q]),
      .pending_o (pending_o[q]),
      .db_bad_o  (db_bad[q])
    );
  end

  sq_fetch_ctrl #(.NUM_Q(NUM_Q), .QID_W(QID_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fetch_req_i (fetch_req_i),
    .fetch_qid_i (fetch_qid_i),
    .pending_i   (pending_o),
    .base_i      (base_v),
    .head_i      (head_v),
    .mem_rvalid_i(mem_rvalid_i),
    .ready_o     (fetch_ready_o),
    .adv_o       (adv),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .cur_qid_o   (cur_qid),
    .rsp_o       (rsp)
  );

  // out-of-range queue number is also a rejected doorbell
  assign db_err_d = db_we_i & ((db_sel == '0) | (|(db_sel & db_bad)));

  always_comb begin
    cur_head = '0;
    for (int q = 0; q < NUM_Q; q++)
      if (cur_qid == QID_W'(q)) cur_head = head_v[q];
  end

  dw0_fields_t fld;
  assign fld = split_dw0(mem_rdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      db_err_q      <= 1'b0;
      cmd_valid_o   <= 1'b0;
      cmd_qid_o     <= '0;
      cmd_admin_o   <= 1'b0;
      cmd_opc_o     <= '0;
      cmd_fuse_o    <= '0;
      cmd_psdt_o    <= '0;
      cmd_cid_o     <= '0;
      cmd_sq_head_o <= '0;
    end else begin
      db_err_q    <= db_err_d;
      cmd_valid_o <= rsp;
      if (rsp) begin
        cmd_qid_o     <= cur_qid;
        cmd_admin_o   <= (cur_qid == '0);
        cmd_opc_o     <= fld.opc;
        cmd_fuse_o    <= fld.fuse;
        cmd_psdt_o    <= fld.psdt;
        cmd_cid_o     <= fld.cid;
        cmd_sq_head_o <= cur_head;
      end
    end
  end
  assign db_err_o = db_err_q;

  a_r7_cmd_follows_response: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(mem_rvalid_i));
  a_r3_err_is_pulse_per_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_err_o |-> $past(db_we_i));
  a_r8_admin_only_queue0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_admin_o) |-> (cmd_qid_o == '0));
endmodule

// File: tb/sq_fetch_tracker_tb.sv
module sq_fetch_tracker_tb;
  localparam int NUM_Q = 3;
  localparam int IDX_W = 3;
  localparam int ADDR_W = 32;
  localparam int QID_W = 2;

  logic clk_i = 0, rst_ni = 0;
  logic cfg_we_i = 0, cfg_en_i = 0;
  logic [QID_W-1:0] cfg_qid_i = 0, db_qid_i = 0, fetch_qid_i = 0;
  logic [ADDR_W-1:0] cfg_base_i = 0;
  logic [IDX_W:0] cfg_size_i = 0;
  logic db_we_i = 0, fetch_req_i = 0;
  logic [IDX_W-1:0] db_tail_i = 0;
  logic db_err_o, fetch_ready_o, mem_req_o, mem_rvalid_i, cmd_valid_o, cmd_admin_o;
  logic [NUM_Q-1:0] pending_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [31:0] mem_rdata_i;
  logic [QID_W-1:0] cmd_qid_o;
  logic [7:0] cmd_opc_o;
  logic [1:0] cmd_fuse_o, cmd_psdt_o;
  logic [15:0] cmd_cid_o;
  logic [IDX_W-1:0] cmd_sq_head_o;

  int n_chk = 0, n_bad = 0;
  int hd[NUM_Q], tl[NUM_Q], sz[NUM_Q];
  bit en[NUM_Q];
  logic [ADDR_W-1:0] bs[NUM_Q];

  always #5 clk_i = ~clk_i;

  function automatic logic [31:0] slot_word(logic [ADDR_W-1:0] a);
    return {a[21:6] ^ 16'hC0DE, a[7:6] + 2'd1, a[9:6] ^ 4'hA, a[8:7], a[13:6] ^ 8'h3C};
  endfunction

  assign mem_rvalid_i = mem_req_o;
  assign mem_rdata_i  = slot_word(mem_addr_o);

  sq_fetch_tracker #(.NUM_Q(NUM_Q), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dut (.*);

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pend_check(string req);
    for (int q = 0; q < NUM_Q; q++)
      check(pending_o[q] == (en[q] && hd[q] != tl[q]), req, "pending", pending_o[q], en[q] && hd[q] != tl[q]);
  endtask

  task automatic configure(int q, bit e, logic [ADDR_W-1:0] b, int s);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_qid_i = QID_W'(q); cfg_en_i = e; cfg_base_i = b; cfg_size_i = (IDX_W+1)'(s);
    @(negedge clk_i);
    cfg_we_i = 0;
    en[q] = e; bs[q] = b; sz[q] = s; hd[q] = 0; tl[q] = 0;
    pend_check("R9");
  endtask

  task automatic doorbell(int q, int v);
    bit ok;
    ok = (q < NUM_Q) && en[q] && (v < sz[q]);
    @(negedge clk_i);
    db_we_i = 1; db_qid_i = QID_W'(q); db_tail_i = IDX_W'(v);
    @(negedge clk_i);
    db_we_i = 0;
    if (ok) tl[q] = v;
    check(db_err_o == !ok, ok ? "R2" : "R3", "db_err", db_err_o, !ok);
    pend_check(ok ? "R2" : "R3");
    @(negedge clk_i);
    check(db_err_o == 0, "R3", "db_err width", db_err_o, 0);
  endtask

  task automatic fetch(int q);
    bit go;
    logic [ADDR_W-1:0] ea;
    logic [31:0] w;
    go = (q < NUM_Q) && en[q] && hd[q] != tl[q];
    @(negedge clk_i);
    fetch_req_i = 1; fetch_qid_i = QID_W'(q);
    @(negedge clk_i);
    fetch_req_i = 0;
    if (!go) begin
      check(mem_req_o == 0, "R6", "mem_req", mem_req_o, 0);
      @(negedge clk_i);
      check(cmd_valid_o == 0, "R6", "cmd_valid", cmd_valid_o, 0);
      return;
    end
    ea = bs[q] + ADDR_W'(hd[q] * 64);
    w = slot_word(ea);
    check(mem_req_o == 1, "R4", "mem_req", mem_req_o, 1);
    check(mem_addr_o == ea, "R4", "addr", mem_addr_o, ea);
    check(fetch_ready_o == 0, "R10", "ready busy", fetch_ready_o, 0);
    hd[q] = (hd[q] + 1 == sz[q]) ? 0 : hd[q] + 1;
    @(negedge clk_i);
    check(mem_req_o == 0, "R10", "mem_req pulse", mem_req_o, 0);
    check(cmd_valid_o == 1, "R7", "cmd_valid", cmd_valid_o, 1);
    check(cmd_opc_o == w[7:0], "R7", "opc", cmd_opc_o, w[7:0]);
    check(cmd_fuse_o == w[9:8], "R7", "fuse", cmd_fuse_o, w[9:8]);
    check(cmd_psdt_o == w[15:14], "R7", "psdt", cmd_psdt_o, w[15:14]);
    check(cmd_cid_o == w[31:16], "R7", "cid", cmd_cid_o, w[31:16]);
    check(cmd_qid_o == QID_W'(q), "R8", "qid", cmd_qid_o, q);
    check(cmd_admin_o == (q == 0), "R8", "admin", cmd_admin_o, q == 0);
    check(cmd_sq_head_o == IDX_W'(hd[q]), "R5", "head", cmd_sq_head_o, hd[q]);
    check(fetch_ready_o == 1, "R10", "ready", fetch_ready_o, 1);
    pend_check("R5");
    @(negedge clk_i);
    check(cmd_valid_o == 0, "R7", "cmd pulse", cmd_valid_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual %0d expected %0d", n_chk, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int q = 0; q < NUM_Q; q++) begin hd[q] = 0; tl[q] = 0; sz[q] = 0; en[q] = 0; bs[q] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    check(pending_o == 0, "R1", "pending", pending_o, 0);
    check(mem_req_o == 0, "R1", "mem_req", mem_req_o, 0);
    check(cmd_valid_o == 0, "R1", "cmd_valid", cmd_valid_o, 0);
    check(db_err_o == 0, "R1", "db_err", db_err_o, 0);
    check(fetch_ready_o == 1, "R1", "ready", fetch_ready_o, 1);
    fetch(0);          // R6 nothing configured
    doorbell(1, 1);    // R3 disabled queue
    configure(0, 1, 32'h0000_1000, 4);
    configure(1, 1, 32'h0020_0040, 8);
    configure(2, 1, 32'h0003_0000, 5);
    for (int r = 0; r < 4; r++) begin
      for (int q = 0; q < NUM_Q; q++) begin
        int n;
        n = (r + q) % (sz[q] - 1) + 1;
        doorbell(q, (tl[q] + n) % sz[q]);
        for (int k = 0; k < n; k++) fetch(q);
        fetch(q);      // R6 now empty
        if (sz[q] < 8) doorbell(q, sz[q]);  // R3 index out of range
        fetch(q);
      end
      doorbell(3, 0);  // R3 bad queue number
      fetch(3);        // R6 bad queue number
    end
    // R9 reconfigure clears pending state
    doorbell(1, (tl[1] + 3) % 8);
    configure(1, 1, 32'h0040_0000, 6);
    fetch(1);
    doorbell(1, 5);
    for (int k = 0; k < 5; k++) fetch(1);
    doorbell(2, (tl[2] + 2) % 5);
    configure(2, 0, 32'h0003_0000, 5);
    doorbell(2, 1);    // R3 disabled
    fetch(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule